// File: doc/BRIEF.md
# Trimmable One-Second Tick Divider

This block turns a free-running 32 kHz clock into a one-second timing tick. A programmable divider sets how many input cycles make up one tick period. To correct for a crystal that runs slightly fast, a trim step stretches one tick period in every 1024. During that step a programmed number of input cycles is skipped before the divider starts counting again. The tick is a one-cycle pulse in the 32 kHz domain that a seconds counter consumes.

Software controls the block through one 32-bit trim word. The word holds the divider value, the skip count and a lock flag. Once the lock flag is set, the whole word is frozen until the next reset. The word is written through a single-cycle write strobe, and its current value is always visible on a read-back port.

Top module: `hz_tick_gen`

## Requirements
- R1: After reset the read-back word is 0x00007FFF: divider 0x7FFF, skip count 0, lock clear. The tick output is low while reset is held.
- R2: While unlocked, a write strobe stores the fields on the next rising clock edge. Bits 15:0 hold the divider value, bits 25:16 hold the skip count and bit 31 holds the lock flag. The new value is visible on the read-back port from that edge on.
- R3: Bits 30:26 of the read-back word are always 0, whatever was written to them.
- R4: While the lock flag reads 1, writes change nothing. The read-back word and the tick period both stay as they were.
- R5: Only reset clears the lock flag. A write with bit 31 at 0 leaves a set lock in place.
- R6: With divider value D of at least 1, the tick is a one-cycle pulse, and consecutive ticks are D+1 clock cycles apart.
- R7: Ticks are counted from reset. The period that begins with tick number 1024, 2048 and so on is stretched to S+D+1 cycles, where S is a nonzero skip count. No tick occurs during the skipped cycles.
- R8: A skip count of 0 disables trimming, so every period, including those after tick 1024 and tick 2048, is exactly D+1 cycles.
- R9: If the divider value is lowered below the current count, the tick fires in the first cycle after the write.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32 kHz input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the trim word |
| wr_data | input | 32 | Trim word to store |
| rd_data | output | 32 | Current trim word |
| tick | output | 1 | One-cycle pulse per tick period |

## Verification
The assertions check the register side on every cycle:
- the reserved bits read as 0;
- an unlocked write is stored exactly;
- a locked word neither changes nor unlocks;
- a tick lasts a single cycle when the divider is nonzero;
- a skip step starts only right after a tick.

Only the bench scenarios can show the timing behaviour. These are the exact spacing between ticks for several random divider values, the stretched period after tick 1024, and the missing stretch after tick 2048 with a zero skip count. The bench also shows the early tick after the divider is lowered, and that a lock also freezes the tick period.

// File: rtl/hz_tick_gen.sv
module hz_tick_gen #(
  parameter int DIV_W      = 16,
  parameter int DEL_W      = 10,
  parameter int TRIM_TICKS = 1024,
  parameter logic [DIV_W-1:0] DIV_INIT = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        tick
);
  localparam int RSV_W = 31 - DIV_W - DEL_W;
  localparam int PW    = $clog2(TRIM_TICKS);

  logic             lock_q;
  logic [DEL_W-1:0] del_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DEL_W-1:0] skip_q;
  logic             skipping;
  logic [PW-1:0]    pcnt_q;
  logic             trim_now;

  assign rd_data  = {lock_q, {RSV_W{1'b0}}, del_q, div_q};
  assign tick     = !skipping && (cnt_q >= div_q);
  assign trim_now = tick && (pcnt_q == PW'(TRIM_TICKS - 1)) && (del_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      del_q  <= '0;
      div_q  <= DIV_INIT;
    end else if (wr_en && !lock_q) begin
      lock_q <= wr_data[31];
      del_q  <= wr_data[DIV_W +: DEL_W];
      div_q  <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (tick)
      pcnt_q <= (pcnt_q == PW'(TRIM_TICKS - 1)) ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      skip_q   <= '0;
      skipping <= 1'b0;
    end else if (skipping) begin
      if (skip_q == '0) skipping <= 1'b0;
      else              skip_q   <= skip_q - 1'b1;
    end else if (trim_now) begin
      cnt_q    <= '0;
      skip_q   <= del_q - 1'b1;
      skipping <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

module hz_tick_gen_chk #(
  parameter int DIV_W = 16,
  parameter int DEL_W = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        tick,
  input logic        skipping
);
  localparam logic [31:0] KEEP = {1'b1, {(31-DIV_W-DEL_W){1'b0}}, {(DIV_W+DEL_W){1'b1}}};

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~KEEP) == 32'd0); // R3
  AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_data[31] |=> rd_data == ($past(wr_data) & KEEP)); // R2
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |=> $stable(rd_data)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |=> rd_data[31]); // R5
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && rd_data[DIV_W-1:0] != '0 |=> !tick); // R6
  AST_SKIP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skipping) |-> $past(tick)); // R7
endmodule

bind hz_tick_gen hz_tick_gen_chk #(.DIV_W(DIV_W), .DEL_W(DEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick(tick), .skipping(skipping)
);

// File: tb/hz_tick_gen_tb.sv
module hz_tick_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick;

  int vectors = 0;
  int errors  = 0;
  int cyc = 0, last_t = 0, idx = 0;
  bit have_last = 0, mon_en = 0;
  int exp_div = 32'h7FFF, exp_del = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_tick_gen u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                     .rd_data(rd_data), .tick(tick));

  function automatic logic [31:0] word_of(input int dv, input int dl, input bit lk);
    return {lk, 5'd0, 10'(dl), 16'(dv)};
  endfunction

  function automatic int period_of(input int prev_idx);
    if (prev_idx % 1024 == 0 && exp_del != 0) return exp_del + exp_div + 1;
    return exp_div + 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && tick) begin
      if (mon_en && have_last) begin
        vectors++;
        if (cyc - last_t != period_of(idx)) begin
          errors++;
          $display("FAIL %s tick %0d interval actual=%0d expected=%0d",
                   (idx % 1024 == 0) ? "R7/R8" : "R6", idx + 1, cyc - last_t, period_of(idx));
        end
      end
      idx++;
      last_t = cyc;
      have_last = 1;
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic program_cfg(input int dv, input int dl);
    mon_en = 0;
    wr(word_of(dv, dl, 1'b0));
    exp_div = dv; exp_del = dl;
    chk("R2 readback", rd_data, word_of(dv, dl, 1'b0));
    wait_tick();
    @(posedge clk); mon_en = 1;
  endtask

  task automatic run_until(input int target);
    while (idx < target) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0000_7FFF);
    chk("R1 tick low", {31'd0, tick}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 32'h0000_7FFF);

    program_cfg(100, 0);
    run_until(idx + 3);
    mon_en = 0;
    wait_tick();
    repeat (50) @(negedge clk);
    wr(word_of(10, 0, 1'b0));
    exp_div = 10;
    chk("R9 early tick", {31'd0, tick}, 32'd1);
    wait_tick();
    @(posedge clk); mon_en = 1;
    run_until(idx + 4);

    wr(32'h7C00_0000 | word_of(7, 3, 1'b0));
    chk("R3 reserved bits zero", rd_data, word_of(7, 3, 1'b0));
    program_cfg(3, 5);
    run_until(1100);

    for (int k = 0; k < 6; k++) begin
      int dv = 1 + int'($urandom_range(0, 29));
      int dl = int'($urandom_range(0, 20));
      program_cfg(dv, dl);
      run_until(idx + 60);
    end

    program_cfg(2, 0);
    run_until(2100);

    program_cfg(4, 6);
    mon_en = 0;
    wr(32'hFC00_0000 | word_of(4, 6, 1'b1));
    chk("R3 reserved with lock", rd_data, word_of(4, 6, 1'b1));
    wait_tick();
    @(posedge clk); mon_en = 1;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] junk = $urandom;
      wr(junk);
      chk("R4 locked write ignored", rd_data, word_of(4, 6, 1'b1));
    end
    wr(word_of(9, 0, 1'b0));
    chk("R5 lock stays set", {31'd0, rd_data[31]}, 32'd1);
    run_until(idx + 20);

    mon_en = 0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R5 reset clears lock", rd_data, 32'h0000_7FFF);
    rst_n = 1'b1;
    wr(word_of(5, 1, 1'b0));
    chk("R5 writable after reset", rd_data, word_of(5, 1, 1'b0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule